// File: doc/BRIEF.md
# Converter Register Initialization Sequencer

This block brings a data converter into its working configuration after power-up. When `start` is seen, it first holds the converter's active-low reset pin low for a set number of system clocks. It then waits a further set number of clocks for the converter to settle. After that it sends a fixed, strictly ordered list of register writes over a three-wire serial control port, made of a serial clock, a serial data line and an active-low chip select.

The list holds four writes. A fifth write is added at the end when the `ac_coupled` input is high at the moment `start` is accepted. `busy` stays high while the sequence runs. `done` rises once the last frame has left and stays high until the next start. The serial clock is the system clock divided by a parameter. Data is launched on the falling edge of the serial clock so the converter can sample it on the rising edge.

Top module: `rsq_init_seq`

## Requirements
- R1: After reset, `ser_cs_n` and `conv_rst_n` are high, while `ser_clk`, `busy` and `done` are low.
- R2: An accepted start drives `conv_rst_n` low once, for exactly RST_CYCLES clocks. `ser_cs_n` stays high while it is low. Exactly WAKE_CYCLES clocks with `conv_rst_n` high then pass before `ser_cs_n` first falls.
- R3: Each frame has exactly 24 rising `ser_clk` edges while `ser_cs_n` is low. The bits are an 8-bit register address followed by 16-bit data, most significant bit first.
- R4: `ser_data` never changes while `ser_clk` is high, and `ser_clk` is low whenever `ser_cs_n` is high. A `ser_clk` period is CLK_DIV system clocks, split into a low half and a high half of equal length.
- R5: The frames come in this order: address 0x03 with data 0x0002, then 0x01 with 0x0010, then 0xC7 with 0x8001, then 0xDE with 0x01C0.
- R6: If `ac_coupled` is high when start is accepted, a fifth frame follows: address 0xE2 with data 0x00C0. Changes of `ac_coupled` after that point do not alter the list.
- R7: Between two frames of one sequence, `ser_cs_n` stays high for exactly GAP_SCLKS×CLK_DIV system clocks. GAP_SCLKS must be at least 2.
- R8: `busy` is high from the clock after start until the last frame ends. `done` then goes high and holds until a new start. `busy` and `done` are never high together.
- R9: A `start` that arrives while `busy` is high is ignored. It causes no new reset pulse and no extra frames.
- R10: A `start` given after `done` runs the whole sequence again from the reset pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| start | input | 1 | Request to run the sequence; sampled on the clock edge |
| ac_coupled | input | 1 | Input-coupling flag; sampled when start is accepted |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence complete; held until the next start |
| conv_rst_n | output | 1 | Active-low reset to the converter |
| ser_clk | output | 1 | Serial control clock |
| ser_data | output | 1 | Serial control data, launched on the falling edge of ser_clk |
| ser_cs_n | output | 1 | Active-low chip select of the serial port |

## Verification
The bench builds the block with CLK_DIV=4, RST_CYCLES=5, WAKE_CYCLES=7 and GAP_SCLKS=2. These values exercise the counter-based serial clock divider and keep every phase a few clocks long, so the exact lengths of the reset pulse, the settle wait and the chip-select gap can be compared against their formulas. With these short runs, one test can fit several stray start pulses and flips of the coupling flag inside a single sequence. Runs are also repeated back to back, with and without the extra write.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
   localparam int ADDR_W      = 8;
   localparam int DATA_W      = 16;
   localparam int FRAME_W     = ADDR_W + DATA_W;
   localparam int BASE_WRITES = 4;
   localparam int MAX_WRITES  = BASE_WRITES + 1;
   localparam int IDX_W       = $clog2(MAX_WRITES);

   typedef struct packed {
      logic [ADDR_W-1:0] addr;
      logic [DATA_W-1:0] data;
   } wr_pair_t;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_RST  = 3'd1,
      ST_WAKE = 3'd2,
      ST_SEND = 3'd3,
      ST_GAP  = 3'd4,
      ST_DONE = 3'd5
   } seq_state_t;
endpackage

// File: rtl/rsq_script.sv
module rsq_script
   import rsq_pkg::*;
(
   input  logic [IDX_W-1:0] idx,
   input  logic             ac_mode,
   output wr_pair_t         pair,
   output logic [IDX_W-1:0] last_idx
);
   // Fixed write list; the order is part of the behaviour.
   always_comb begin
      case (idx)
         IDX_W'(0): pair = '{addr: 8'h03, data: 16'h0002};
         IDX_W'(1): pair = '{addr: 8'h01, data: 16'h0010};
         IDX_W'(2): pair = '{addr: 8'hC7, data: 16'h8001};
         IDX_W'(3): pair = '{addr: 8'hDE, data: 16'h01C0};
         IDX_W'(4): pair = '{addr: 8'hE2, data: 16'h00C0};
         default:   pair = '{addr: '0, data: '0};
      endcase
   end

   assign last_idx = ac_mode ? IDX_W'(MAX_WRITES - 1) : IDX_W'(BASE_WRITES - 1);
endmodule

// File: rtl/rsq_sclk_gen.sv
module rsq_sclk_gen #(
   parameter int CLK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic sclk,
   output logic rise_stb,
   output logic fall_stb
);
   localparam int HALF = CLK_DIV / 2;
   localparam int CW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;

   logic sclk_q;

   generate
      if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("rsq_sclk_gen: CLK_DIV must be even and at least 2");
      end

      if (CLK_DIV == 2) begin : g_toggle
         assign rise_stb = run && !sclk_q;
         assign fall_stb = run && sclk_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      sclk_q <= 1'b0;
            else if (!run)   sclk_q <= 1'b0;
            else             sclk_q <= !sclk_q;
         end
      end else begin : g_counter
         logic [CW-1:0] cnt;
         assign rise_stb = run && (cnt == CW'(HALF - 1));
         assign fall_stb = run && (cnt == CW'(CLK_DIV - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt    <= '0;
               sclk_q <= 1'b0;
            end else if (!run) begin
               cnt    <= '0;
               sclk_q <= 1'b0;
            end else begin
               cnt <= fall_stb ? '0 : cnt + 1'b1;
               if (rise_stb)      sclk_q <= 1'b1;
               else if (fall_stb) sclk_q <= 1'b0;
            end
         end
      end
   endgenerate

   assign sclk = sclk_q;

   AST_SCLK_PARKS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> !sclk)  // R4
      else $error("ser_clk not parked low");
endmodule

// File: rtl/rsq_frame_tx.sv
module rsq_frame_tx #(
   parameter int FRAME_W = 24
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [FRAME_W-1:0] frame,
   input  logic               shift_stb,
   output logic               sdata,
   output logic               frame_end
);
   localparam int CNT_W = $clog2(FRAME_W + 1);

   logic [FRAME_W-1:0] shreg;
   logic [CNT_W-1:0]   bitcnt;

   generate
      if (FRAME_W < 2) begin : g_bad_w
         $error("rsq_frame_tx: FRAME_W too small");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg  <= '0;
         bitcnt <= '0;
      end else if (load) begin
         shreg  <= frame;
         bitcnt <= '0;
      end else if (shift_stb) begin
         shreg  <= {shreg[FRAME_W-2:0], 1'b0};
         bitcnt <= bitcnt + 1'b1;
      end
   end

   assign sdata     = shreg[FRAME_W-1];
   assign frame_end = shift_stb && (bitcnt == CNT_W'(FRAME_W - 1));

   AST_NO_OVERSHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      shift_stb |-> (bitcnt < CNT_W'(FRAME_W)))  // R3
      else $error("frame shifter ran past its width");
endmodule

// File: rtl/rsq_init_seq.sv
module rsq_init_seq
   import rsq_pkg::*;
#(
   parameter int CLK_DIV     = 4,
   parameter int RST_CYCLES  = 16,
   parameter int WAKE_CYCLES = 32,
   parameter int GAP_SCLKS   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic ac_coupled,
   output logic busy,
   output logic done,
   output logic conv_rst_n,
   output logic ser_clk,
   output logic ser_data,
   output logic ser_cs_n
);
   localparam int GAP_CYCLES = GAP_SCLKS * CLK_DIV;
   localparam int LONG_RW    = (RST_CYCLES > WAKE_CYCLES) ? RST_CYCLES : WAKE_CYCLES;
   localparam int LONGEST    = (LONG_RW > GAP_CYCLES) ? LONG_RW : GAP_CYCLES;
   localparam int TW         = $clog2(LONGEST + 1);

   generate
      if (GAP_SCLKS < 2) begin : g_bad_gap
         $error("rsq_init_seq: GAP_SCLKS must be at least 2");
      end
      if (RST_CYCLES < 1 || WAKE_CYCLES < 1) begin : g_bad_time
         $error("rsq_init_seq: RST_CYCLES and WAKE_CYCLES must be positive");
      end
   endgenerate

   seq_state_t       state;
   logic [TW-1:0]    tcnt;
   logic [IDX_W-1:0] idx;
   logic             ac_q;

   wr_pair_t         pair;
   logic [IDX_W-1:0] last_idx;
   logic             sclk_rise, sclk_fall, frame_end, enter_send;

   rsq_script u_script (
      .idx      (idx),
      .ac_mode  (ac_q),
      .pair     (pair),
      .last_idx (last_idx)
   );

   rsq_sclk_gen #(.CLK_DIV(CLK_DIV)) u_sclk (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (state == ST_SEND),
      .sclk     (ser_clk),
      .rise_stb (sclk_rise),
      .fall_stb (sclk_fall)
   );

   rsq_frame_tx #(.FRAME_W(FRAME_W)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (enter_send),
      .frame     (pair),
      .shift_stb (sclk_fall),
      .sdata     (ser_data),
      .frame_end (frame_end)
   );

   assign enter_send = ((state == ST_WAKE) && (tcnt == TW'(WAKE_CYCLES - 1))) ||
                       ((state == ST_GAP)  && (tcnt == TW'(GAP_CYCLES - 1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         tcnt  <= '0;
         idx   <= '0;
         ac_q  <= 1'b0;
      end else begin
         case (state)
            ST_IDLE, ST_DONE: begin
               if (start) begin
                  state <= ST_RST;
                  tcnt  <= '0;
                  idx   <= '0;
                  ac_q  <= ac_coupled;
               end
            end
            ST_RST: begin
               if (tcnt == TW'(RST_CYCLES - 1)) begin
                  state <= ST_WAKE;
                  tcnt  <= '0;
               end else begin
                  tcnt <= tcnt + 1'b1;
               end
            end
            ST_WAKE: begin
               if (enter_send) begin
                  state <= ST_SEND;
                  tcnt  <= '0;
               end else begin
                  tcnt <= tcnt + 1'b1;
               end
            end
            ST_SEND: begin
               if (frame_end) begin
                  tcnt <= '0;
                  if (idx == last_idx) begin
                     state <= ST_DONE;
                  end else begin
                     state <= ST_GAP;
                     idx   <= idx + 1'b1;
                  end
               end
            end
            ST_GAP: begin
               if (enter_send) begin
                  state <= ST_SEND;
                  tcnt  <= '0;
               end else begin
                  tcnt <= tcnt + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy       = (state == ST_RST) || (state == ST_WAKE) ||
                       (state == ST_SEND) || (state == ST_GAP);
   assign done       = (state == ST_DONE);
   assign conv_rst_n = (state != ST_RST);
   assign ser_cs_n   = (state != ST_SEND);

   AST_RST_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      !conv_rst_n |-> ser_cs_n)  // R2
      else $error("frame during converter reset");
   AST_CS_IDLE_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
      ser_cs_n |-> !ser_clk)  // R4
      else $error("ser_clk high with chip select released");
   AST_DATA_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_clk && $past(ser_clk)) |-> $stable(ser_data))  // R4
      else $error("ser_data moved while ser_clk high");
   AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (idx <= last_idx))  // R5
      else $error("write index beyond list");
   AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done))  // R8
      else $error("busy and done together");
   AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done)  // R8
      else $error("done dropped without start");
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (((state == ST_SEND) || (state == ST_GAP) || (state == ST_WAKE)) && start)
         |=> (state != ST_RST))  // R9
      else $error("start restarted a running sequence");
endmodule

// File: tb/rsq_init_seq_test.sv
module rsq_init_seq_test;
   localparam int CLK_PERIOD  = 10;
   localparam int DIV         = 4;
   localparam int RSTC        = 5;
   localparam int WAKEC       = 7;
   localparam int GAPS        = 2;
   localparam int GAPC        = GAPS * DIV;
   localparam int CAP_DEPTH   = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic ac_coupled = 1'b0;
   logic busy, done, conv_rst_n, ser_clk, ser_data, ser_cs_n;

   int nchk = 0;
   int nfail = 0;

   rsq_init_seq #(.CLK_DIV(DIV), .RST_CYCLES(RSTC), .WAKE_CYCLES(WAKEC),
                  .GAP_SCLKS(GAPS)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .ac_coupled(ac_coupled),
      .busy(busy), .done(done), .conv_rst_n(conv_rst_n),
      .ser_clk(ser_clk), .ser_data(ser_data), .ser_cs_n(ser_cs_n)
   );

   always #(CLK_PERIOD/2) clk = !clk;

   // Serial slave: sample on rising ser_clk, close the frame on cs rise.
   logic [23:0] cap      [CAP_DEPTH];
   int          cap_bits [CAP_DEPTH];
   int          ncap = 0;
   logic [23:0] sh = '0;
   int          nbits = 0;

   always @(posedge ser_clk or posedge ser_cs_n) begin
      if (ser_cs_n) begin
         if (nbits != 0) begin
            if (ncap < CAP_DEPTH) begin
               cap[ncap]      = sh;
               cap_bits[ncap] = nbits;
            end
            ncap  = ncap + 1;
            nbits = 0;
         end
      end else begin
         sh    = {sh[22:0], ser_data};
         nbits = nbits + 1;
      end
   end

   // Timing monitor, sampled mid-cycle.
   int   rst_lo = 0, rst_pulses = 0, since_rst = 0, wake_meas = -1;
   int   cs_hi_run = 0, gap_seen = 0, gap_bad = 0, hold_bad = 0, cyc = 0;
   logic first_pending = 1'b0;
   logic p_rst = 1'b1, p_cs = 1'b1, p_sclk = 1'b0, p_data = 1'b0;

   always @(negedge clk) begin
      cyc = cyc + 1;
      if (rst_n) begin
         if (p_cs && !ser_cs_n) begin
            if (first_pending) begin
               wake_meas     = since_rst;
               first_pending = 1'b0;
            end else begin
               gap_seen = gap_seen + 1;
               if (cs_hi_run != GAPC) gap_bad = gap_bad + 1;
            end
         end
         if (!conv_rst_n) begin
            rst_lo        = rst_lo + 1;
            since_rst     = 0;
            first_pending = 1'b1;
            if (p_rst) rst_pulses = rst_pulses + 1;
         end else begin
            since_rst = since_rst + 1;
         end
         cs_hi_run = ser_cs_n ? cs_hi_run + 1 : 0;
         if (p_sclk && ser_clk && (ser_data != p_data)) hold_bad = hold_bad + 1;
      end
      p_rst  = conv_rst_n;
      p_cs   = ser_cs_n;
      p_sclk = ser_clk;
      p_data = ser_data;
      if (cyc > 150000) begin
         nfail = nfail + 1;
         $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   function automatic logic [23:0] exp_frame(input int i);
      case (i)
         0: return 24'h03_0002;
         1: return 24'h01_0010;
         2: return 24'hC7_8001;
         3: return 24'hDE_01C0;
         4: return 24'hE2_00C0;
         default: return 24'h0;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      nchk = nchk + 1;
      if (!ok) begin
         nfail = nfail + 1;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic pulse_start(input logic ac);
      @(negedge clk);
      start      = 1'b1;
      ac_coupled = ac;
      @(negedge clk);
      start      = 1'b0;
   endtask

   task automatic wait_done();
      for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
   endtask

   task automatic t_reset_state();
      chk(ser_cs_n == 1'b1,   "R1", "cs_n idle",     ser_cs_n, 1);
      chk(conv_rst_n == 1'b1, "R1", "conv_rst_n",    conv_rst_n, 1);
      chk(ser_clk == 1'b0,    "R1", "ser_clk idle",  ser_clk, 0);
      chk(busy == 1'b0,       "R1", "busy",          busy, 0);
      chk(done == 1'b0,       "R1", "done",          done, 0);
   endtask

   // One full run; disturb adds stray starts and coupling-flag flips mid-run.
   task automatic t_run(input logic ac, input bit disturb, input string tag);
      int b_cap = ncap, b_lo = rst_lo, b_pl = rst_pulses;
      int b_gs = gap_seen, b_gb = gap_bad, b_hb = hold_bad;
      int nexp = ac ? 5 : 4;
      pulse_start(ac);
      chk(busy == 1'b1 && done == 1'b0, "R8", {tag, " busy after start"}, {busy, done}, 2);
      if (disturb) begin
         for (int k = 0; k < 3; k++) begin
            repeat (60) @(negedge clk);
            pulse_start(!ac);      // R9 stray start, R6 flag flip
         end
         ac_coupled = ac;
      end
      wait_done();
      chk(done == 1'b1 && busy == 1'b0, "R8", {tag, " done at end"}, {busy, done}, 1);
      chk(ncap - b_cap == nexp, ac ? "R6" : "R5", {tag, " frame count"}, ncap - b_cap, nexp);
      for (int i = 0; i < nexp && (b_cap + i) < CAP_DEPTH && i < ncap - b_cap; i++) begin
         chk(cap_bits[b_cap + i] == 24, "R3", {tag, " bits in frame"}, cap_bits[b_cap + i], 24);
         chk(cap[b_cap + i] == exp_frame(i), (i == 4) ? "R6" : "R5", {tag, " frame content"},
             cap[b_cap + i], exp_frame(i));
      end
      chk(rst_pulses - b_pl == 1, disturb ? "R9" : "R2", {tag, " reset pulses"}, rst_pulses - b_pl, 1);
      chk(rst_lo - b_lo == RSTC, "R2", {tag, " reset width"}, rst_lo - b_lo, RSTC);
      chk(wake_meas == WAKEC, "R2", {tag, " settle wait"}, wake_meas, WAKEC);
      chk(gap_seen - b_gs == nexp - 1, "R7", {tag, " gaps seen"}, gap_seen - b_gs, nexp - 1);
      chk(gap_bad == b_gb, "R7", {tag, " gap length"}, gap_bad - b_gb, 0);
      chk(hold_bad == b_hb, "R4", {tag, " data stable while clk high"}, hold_bad - b_hb, 0);
      repeat (12) @(negedge clk);
      chk(done == 1'b1 && ncap - b_cap == nexp, "R8", {tag, " done holds, no more frames"},
          ncap - b_cap, nexp);
      chk(ser_clk == 1'b0 && ser_cs_n == 1'b1, "R4", {tag, " port parked"}, {ser_clk, ser_cs_n}, 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset_state();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset_state();
      t_run(1'b0, 1'b0, "dc run");
      t_run(1'b1, 1'b0, "R10 restart ac run");
      t_run(1'b0, 1'b1, "dc run with stray starts");
      t_run(1'b1, 1'b1, "ac run with stray starts");
      t_run(1'b0, 1'b0, "R10 final restart");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule